// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This controller gathers 128 interrupt slots and gives each one a 4-bit priority. Slots 0 to 7 are software sources, set and cleared through a flag register. Slots 8 to 111 follow peripheral request lines, which are level sensitive. Slots 112 to 127 are reserved and never request. Every cycle the controller finds the pending slot with the highest priority. It raises a request to the processor only when that priority is strictly above the processor's current priority, and it drives the slot index as a 9-bit vector.

Taking an interrupt saves the current priority on a 16-entry priority stack and raises the current priority to that of the accepted slot, so only higher-priority work can preempt the handler. An end-of-interrupt write pops the stack and restores the earlier level. A configuration bit picks one of two handshakes. In the software handshake, the handler reads the acknowledge register, and that read is the acknowledge. In the hardware handshake, the processor pulses an acknowledge pin and takes the vector straight from the vector output.

All registers sit behind a single-cycle word-addressed port. Write data is captured on the clock edge. Read data is combinational in the same cycle.

Top module: `nest_intc`

## Requirements
- R1: After reset the configuration bit, the current priority, the software flags, the last acknowledged vector and every slot priority read as 0, and no request is raised.
- R2: A slot whose priority is 0 is masked and never wins arbitration.
- R3: `irq_req_o` is high only when the best pending priority is strictly greater than the current priority (register word 1, bits 3:0).
- R4: The winner is the pending slot with the highest priority. Among equal priorities the lowest slot index wins. `vec_o` equals the winner's slot index.
- R5: Slots 112 to 127 never request. Bits 0 to 7 and 112 to 127 of `irq_i` have no effect. Slot k, for k from 8 to 111, follows `irq_i[k]`. Slot priorities are at word 128+k, bits 3:0.
- R6: A write to word 4 sets the software flags selected by bits 7:0 and clears those selected by bits 15:8. Flag j drives slot j. A flag stays set across an acknowledge. Word 4 reads the flags in bits 7:0.
- R7: Software handshake (word 0 bit 0 = 0): a read of word 2 while a request is raised returns the vector in bits 8:0, pushes the current priority and loads the winner's priority as the current priority. `ack_i` is ignored.
- R8: Hardware handshake (word 0 bit 0 = 1): `ack_i` while a request is raised performs the push and update. A read of word 2 has no side effect and returns the last acknowledged vector.
- R9: A write to word 3 pops the stack into the current priority. When the stack is empty, the current priority becomes 0.
- R10: The stack holds 16 entries. Pushes made when it is full are dropped, but the current priority is still updated.
- R11: An acknowledge while no request is raised changes nothing.
- R12: A write to word 1 loads the current priority. When an acknowledge happens in the same cycle as a write to word 1 or word 3, the acknowledge wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 128 | Peripheral request levels, indexed by slot |
| reg_addr_i | input | 8 | Register word address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, same cycle |
| ack_i | input | 1 | Processor acknowledge in the hardware handshake |
| irq_req_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 9 | Vector of the winning slot |

## Verification
Arbitration is tried with:
- a single pending slot;
- two slots at equal priority, which checks the lowest-index tie rule;
- a later slot at a higher priority, which shows that priority beats index;
- a top-priority request on a reserved line and on a line shadowed by a software slot, which must both lose.

Nesting is tried as a ladder of acknowledges and end-of-interrupt writes. The current priority is rewritten before each of 18 acknowledges, so the popped values show both the stack order and the point where pushes were dropped. Both handshakes, simultaneous acknowledge and register writes, and acknowledges with nothing pending separate the side effects of each path.

// File: rtl/nest_intc.sv
module nest_intc #(
  parameter int NSRC     = 128,
  parameter int NSW      = 8,
  parameter int NRSV     = 16,
  parameter int PW       = 4,
  parameter int VW       = 9,
  parameter int DEPTH    = 16,
  parameter int AW       = 8,
  parameter int PRI_BASE = 128
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] irq_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic            reg_wr_i,
  input  logic            reg_rd_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  input  logic            ack_i,
  output logic            irq_req_o,
  output logic [VW-1:0]   vec_o
);
  localparam int PERI_HI = NSRC - NRSV;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(DEPTH);
  localparam int IW = $clog2(NSRC);
  localparam logic [AW-1:0] A_CFG = AW'(0);
  localparam logic [AW-1:0] A_CUR = AW'(1);
  localparam logic [AW-1:0] A_ACK = AW'(2);
  localparam logic [AW-1:0] A_EOI = AW'(3);
  localparam logic [AW-1:0] A_FLG = AW'(4);

  logic [PW-1:0]  pri_q [NSRC];
  logic [PW-1:0]  stk_q [DEPTH];
  logic [NSW-1:0] sw_q;
  logic           hwv_q;
  logic [PW-1:0]  cur_q;
  logic [CW-1:0]  cnt_q;
  logic [VW-1:0]  ackv_q;
  logic [NSRC-1:0] req;
  logic [PW-1:0]  win_pri;
  logic [VW-1:0]  win_vec;
  logic           ack_ev;
  logic           pri_hit;
  logic [IW-1:0]  pidx;
  logic [CW-1:0]  top;
  logic           unused_bits;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (g < NSW) begin : g_sw
      assign req[g] = sw_q[g];
    end else if (g < PERI_HI) begin : g_peri
      assign req[g] = irq_i[g];
    end else begin : g_rsv
      assign req[g] = 1'b0;
    end
  end

  assign unused_bits = ^{irq_i[NSW-1:0], irq_i[NSRC-1:PERI_HI], reg_wdata_i[31:16]};

  always_comb begin
    win_pri = '0;
    win_vec = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && pri_q[i] > win_pri) begin
        win_pri = pri_q[i];
        win_vec = VW'(i);
      end
    end
  end

  assign irq_req_o = win_pri > cur_q;
  assign vec_o     = win_vec;
  assign ack_ev    = irq_req_o && (hwv_q ? ack_i : (reg_rd_i && reg_addr_i == A_ACK));
  assign pri_hit   = int'(reg_addr_i) >= PRI_BASE && int'(reg_addr_i) < PRI_BASE + NSRC;
  assign pidx      = IW'(int'(reg_addr_i) - PRI_BASE);
  assign top       = cnt_q - 1'b1;

  always_comb begin
    reg_rdata_o = '0;
    if (pri_hit) reg_rdata_o[PW-1:0] = pri_q[pidx];
    else begin
      case (reg_addr_i)
        A_CFG: reg_rdata_o[0] = hwv_q;
        A_CUR: reg_rdata_o[PW-1:0] = cur_q;
        A_ACK: reg_rdata_o[VW-1:0] = (!hwv_q && irq_req_o) ? win_vec : ackv_q;
        A_FLG: reg_rdata_o[NSW-1:0] = sw_q;
        default: reg_rdata_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSRC; i++) pri_q[i] <= '0;
      sw_q   <= '0;
      hwv_q  <= 1'b0;
      cur_q  <= '0;
      cnt_q  <= '0;
      ackv_q <= '0;
    end else begin
      if (ack_ev) begin
        if (int'(cnt_q) < DEPTH) begin
          stk_q[cnt_q[SW-1:0]] <= cur_q;
          cnt_q <= cnt_q + 1'b1;
        end
        cur_q  <= win_pri;
        ackv_q <= win_vec;
      end
      if (reg_wr_i) begin
        if (pri_hit) pri_q[pidx] <= reg_wdata_i[PW-1:0];
        case (reg_addr_i)
          A_CFG: hwv_q <= reg_wdata_i[0];
          A_CUR: if (!ack_ev) cur_q <= reg_wdata_i[PW-1:0];
          A_EOI: if (!ack_ev) begin
            if (cnt_q != '0) begin
              cur_q <= stk_q[top[SW-1:0]];
              cnt_q <= top;
            end else begin
              cur_q <= '0;
            end
          end
          A_FLG: sw_q <= (sw_q | reg_wdata_i[NSW-1:0]) & ~reg_wdata_i[NSW+7:8];
          default: ;
        endcase
      end
    end
  end
endmodule

module nest_intc_chk #(
  parameter int NSRC  = 128,
  parameter int NRSV  = 16,
  parameter int PW    = 4,
  parameter int VW    = 9,
  parameter int DEPTH = 16,
  parameter int AW    = 8,
  parameter int CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_req_o,
  input logic [VW-1:0] vec_o,
  input logic          ack_ev,
  input logic [PW-1:0] cur_q,
  input logic [CW-1:0] cnt_q,
  input logic [PW-1:0] win_pri,
  input logic          reg_wr_i,
  input logic [AW-1:0] reg_addr_i
);
  // R5
  no_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> int'(vec_o) < NSRC - NRSV);
  // R7
  ack_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_ev |=> cur_q == $past(win_pri));
  // R10
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= DEPTH);
  // R10
  push_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_ev && int'(cnt_q) < DEPTH) |=> int'(cnt_q) == int'($past(cnt_q)) + 1);
  // R9
  eoi_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == AW'(3) && !ack_ev && cnt_q == '0) |=> cur_q == '0);
  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_req_o && !reg_wr_i) |=> ($stable(cur_q) && $stable(cnt_q)));
endmodule

bind nest_intc nest_intc_chk #(
  .NSRC(NSRC), .NRSV(NRSV), .PW(PW), .VW(VW), .DEPTH(DEPTH), .AW(AW), .CW(CW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_req_o(irq_req_o), .vec_o(vec_o),
  .ack_ev(ack_ev), .cur_q(cur_q), .cnt_q(cnt_q), .win_pri(win_pri),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i)
);

// File: tb/nest_intc_tb.sv
module nest_intc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [127:0] irq = '0;
  logic [7:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0, ack = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic req_o;
  logic [8:0] vec;

  always #5 clk = ~clk;

  nest_intc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .ack_i(ack), .irq_req_o(req_o), .vec_o(vec)
  );

  int m_pri[128];
  bit [7:0] m_sw;
  int m_cur, m_ackv;
  bit m_hw;
  int m_stk[$];
  int errs = 0, checks = 0;
  string tag = "R1";
  bit done = 1'b0;

  function automatic void mwin(output int wp, output int wv);
    wp = 0; wv = 0;
    for (int i = 0; i < 128; i++) begin
      bit r;
      r = (i < 8) ? m_sw[i] : (i < 112) ? irq[i] : 1'b0;
      if (r && m_pri[i] > wp) begin wp = m_pri[i]; wv = i; end
    end
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    int wp, wv, er;
    bit rq, ackev;
    #1;
    mwin(wp, wv);
    rq = wp > m_cur;
    chk("irq_req", int'(req_o), int'(rq));
    if (rq) chk("vec", int'(vec), wv);
    if (rd) begin
      case (int'(addr))
        0: er = m_hw;
        1: er = m_cur;
        2: er = (!m_hw && rq) ? wv : m_ackv;
        4: er = m_sw;
        default: er = (addr >= 128) ? m_pri[addr - 128] : 0;
      endcase
      chk("rdata", int'(rdata), er);
    end
    @(posedge clk);
    ackev = rq && (m_hw ? ack : (rd && addr == 2));
    if (ackev) begin
      if (m_stk.size() < 16) m_stk.push_back(m_cur);
      m_cur = wp; m_ackv = wv;
    end
    if (wr) begin
      case (int'(addr))
        0: m_hw = wd[0];
        1: if (!ackev) m_cur = int'(wd[3:0]);
        3: if (!ackev) m_cur = (m_stk.size() > 0) ? m_stk.pop_back() : 0;
        4: m_sw = (m_sw | wd[7:0]) & ~wd[15:8];
        default: if (addr >= 128) m_pri[addr - 128] = int'(wd[3:0]);
      endcase
    end
    @(negedge clk);
    wr = 0; rd = 0; ack = 0;
  endtask

  task automatic wreg(int a, int d);
    addr = 8'(a); wd = 32'(d); wr = 1; step();
  endtask
  task automatic rreg(int a);
    addr = 8'(a); rd = 1; step();
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask
  task automatic hwack();
    ack = 1; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    idle(1); rreg(0); rreg(1); rreg(2); rreg(4); rreg(128); rreg(200);
    tag = "R4";
    wreg(128 + 20, 5); irq[20] = 1; idle(1);
    wreg(128 + 30, 5); irq[30] = 1; idle(1);
    wreg(128 + 40, 7); irq[40] = 1; idle(1);
    tag = "R5";
    wreg(128 + 115, 15); irq[115] = 1; idle(1);
    wreg(128 + 3, 15); irq[3] = 1; idle(1); rreg(128 + 115);
    tag = "R6";
    wreg(4, 'h08); idle(1); rreg(4);
    wreg(4, 'h0801); idle(1); rreg(4);
    tag = "R2";
    wreg(128 + 0, 15); idle(1);
    wreg(128 + 0, 0); idle(1);
    tag = "R3";
    wreg(1, 7); idle(1); wreg(1, 6); idle(1);
    tag = "R12";
    rreg(1);
    tag = "R7";
    wreg(1, 0); hwack(); rreg(1);
    rreg(2); rreg(1);
    wreg(128 + 50, 9); irq[50] = 1; rreg(2); rreg(1);
    wreg(128 + 0, 12); rreg(2); rreg(1);
    tag = "R6";
    rreg(4);
    tag = "R9";
    wreg(3, 0); rreg(1); wreg(3, 0); rreg(1); wreg(3, 0); rreg(1);
    wreg(3, 0); rreg(1);
    tag = "R8";
    wreg(0, 1); rreg(0); hwack(); rreg(2); rreg(1); rreg(2);
    tag = "R11";
    hwack(); rreg(1);
    tag = "R8";
    wreg(128 + 60, 14); irq[60] = 1; hwack(); rreg(2); rreg(1);
    tag = "R10";
    for (int k = 0; k < 5; k++) wreg(3, 0);
    for (int k = 0; k < 18; k++) begin wreg(1, k % 13); hwack(); end
    for (int k = 0; k < 18; k++) begin wreg(3, 0); rreg(1); end
    tag = "R12";
    wreg(1, 0); addr = 3; wr = 1; ack = 1; step(); rreg(1);
    wreg(1, 0); addr = 1; wd = 3; wr = 1; ack = 1; step(); rreg(1);
    tag = "R11";
    irq = '0; wreg(4, 'hFF00); wreg(1, 0); hwack(); rreg(1); rreg(2);
    idle(2);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule